// File: doc/BRIEF.md
# Highest Pending Virtual Interrupt Selector

This block looks at a small bank of 64-bit list entries that describe virtual interrupts and finds the entry that should be signalled next. To qualify, an entry must be in the pending state, its group must be enabled, and its priority value must be below the idle level 0xFF. Among the qualifying entries the lowest priority value wins. When two winners tie, the lower index wins. The winning index, a none flag and the winning entry itself are driven combinationally and are always current.

Software-style queries use a request/response stream. A request carries a group number (0 or 1). The response carries the winner's virtual ID when the winner belongs to that group. Otherwise it carries the spurious ID 1023. A winner from the other group does not pass the query on to the next-best entry. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The answer is evaluated from the entries and enables present at that edge and appears on the next cycle. The response slot holds one answer. It stays valid and unchanged until `rsp_ready` takes it. `req_ready` is high whenever the slot is empty or is being emptied in the same cycle, so back-pressure on the response side stalls the request side with no bubble.

Top module: `vpsel_top`

## Requirements
- R1: Only entries whose state field, bits [63:62], holds 2'b01 (pending) can win. The codes 00 (invalid), 10 (active) and 11 (active and pending) are never selected.
- R2: When both group enables are low, `win_none` is 1 and `win_idx` is 0, whatever the entries hold.
- R3: An entry with group bit 60 set is skipped unless `en_grp1` is high. An entry with bit 60 clear is skipped unless `en_grp0` is high.
- R4: An entry with priority field [55:48] equal to 8'hFF is never reported.
- R5: The winner has the smallest priority value among qualifying entries. On a tie the lowest index wins. `win_lr` equals the winning entry.
- R6: A response carries bits [31:0] of the winner when the winner's bit 60 equals the requested group. Otherwise, and whenever there is no winner, it carries 1023.
- R7: A request accepted at an edge produces `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, `rsp_id` holds and `req_ready` is low. With `rsp_ready` high, a new request is accepted in the same cycle the old answer drains.
- R8: During and straight after reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_flat | input | NUM_LR*64 | List entries; entry i occupies bits [i*64 +: 64] |
| en_grp0 | input | 1 | Virtual group 0 enable |
| en_grp1 | input | 1 | Virtual group 1 enable |
| win_none | output | 1 | No entry qualifies |
| win_idx | output | IDX_W | Index of the winning entry, 0 when none |
| win_lr | output | 64 | Winning entry contents, entry 0 when none |
| req_valid | input | 1 | Query request valid |
| req_ready | output | 1 | Query request can be accepted |
| req_grp | input | 1 | Requested group |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_id | output | 32 | Virtual ID of the winner, or 1023 |

## Verification
The bench builds the block with NUM_LR = 5. This count is not a power of two, so the selection tree has three padding leaves that must never win. The bench also draws priorities from a small set that includes 0xFF. Five entries are enough for ties and for mixed-group contests to come up often in random trials. Directed cases cover an idle bank, a three-way tie, an all-0xFF bank, a winner from the wrong group and a stalled response.

// File: rtl/vpsel_pkg.sv
package vpsel_pkg;

  localparam int unsigned LR_W       = 64;
  localparam int unsigned VID_W      = 32;
  localparam int unsigned PRIO_W     = 8;

  localparam int unsigned VID_LSB    = 0;
  localparam int unsigned PRIO_LSB   = 48;
  localparam int unsigned GRP_BIT    = 60;
  localparam int unsigned STATE_LSB  = 62;

  localparam logic [PRIO_W-1:0] PRIO_IDLE   = 8'hFF;
  localparam logic [VID_W-1:0]  SPURIOUS_ID = 32'd1023;

  typedef enum logic [1:0] {
    ST_INVALID  = 2'b00,
    ST_PENDING  = 2'b01,
    ST_ACTIVE   = 2'b10,
    ST_ACT_PEND = 2'b11
  } lr_state_e;

  typedef struct packed {
    logic              qual;
    logic [PRIO_W-1:0] prio;
  } cand_t;

endpackage

// File: rtl/vpsel_entry_qual.sv
module vpsel_entry_qual
  import vpsel_pkg::*;
(
  input  logic [LR_W-1:0] lr,
  input  logic            en_grp0,
  input  logic            en_grp1,
  output cand_t           cand
);

  lr_state_e         st;
  logic              grp;
  logic [PRIO_W-1:0] prio;
  logic              grp_on;

  always_comb begin
    st     = lr_state_e'(lr[STATE_LSB +: 2]);
    grp    = lr[GRP_BIT];
    prio   = lr[PRIO_LSB +: PRIO_W];
    grp_on = grp ? en_grp1 : en_grp0;
    cand.prio = prio;
    cand.qual = (st == ST_PENDING) && grp_on && (prio < PRIO_IDLE);
  end

endmodule

// File: rtl/vpsel_prio_tree.sv
module vpsel_prio_tree
  import vpsel_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  localparam int unsigned IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
  localparam int unsigned LVL    = (NUM_LR > 1) ? $clog2(NUM_LR) : 0,
  localparam int unsigned LEAVES = 1 << LVL,
  localparam int unsigned NODES  = 2 * LEAVES - 1
) (
  input  cand_t             cands [NUM_LR],
  output logic              root_qual,
  output logic [IDX_W-1:0]  root_idx
);

  cand_t            node_c [NODES];
  logic [IDX_W-1:0] node_i [NODES];

  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < NUM_LR) begin : g_real
      assign node_c[LEAVES-1+l] = cands[l];
      assign node_i[LEAVES-1+l] = IDX_W'(l);
    end else begin : g_pad
      assign node_c[LEAVES-1+l] = '{qual: 1'b0, prio: PRIO_IDLE};
      assign node_i[LEAVES-1+l] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic take_left;
    always_comb begin
      take_left = node_c[2*n+1].qual &&
                  (!node_c[2*n+2].qual || (node_c[2*n+1].prio <= node_c[2*n+2].prio));
    end
    assign node_c[n] = take_left ? node_c[2*n+1] : node_c[2*n+2];
    assign node_i[n] = take_left ? node_i[2*n+1] : node_i[2*n+2];
  end

  assign root_qual = node_c[0].qual;
  assign root_idx  = node_i[0];

endmodule

// File: rtl/vpsel_rsp_slot.sv
module vpsel_rsp_slot
  import vpsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_none,
  input  logic             win_grp,
  input  logic [VID_W-1:0] win_vid,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_grp,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [VID_W-1:0] rsp_id
);

  logic             accept;
  logic [VID_W-1:0] answer;

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    answer    = (!win_none && (win_grp == req_grp)) ? win_vid : SPURIOUS_ID;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= SPURIOUS_ID;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_id    <= answer;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R7: a stalled answer stays put
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id));

  // R7: accepted request yields a response next cycle
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R6: no winner means spurious answer
  p_spur_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && win_none |=> rsp_id == SPURIOUS_ID);

endmodule

// File: rtl/vpsel_top.sv
module vpsel_top
  import vpsel_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  localparam int unsigned IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LR*LR_W-1:0] lr_flat,
  input  logic                   en_grp0,
  input  logic                   en_grp1,
  output logic                   win_none,
  output logic [IDX_W-1:0]       win_idx,
  output logic [LR_W-1:0]        win_lr,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_grp,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [VID_W-1:0]       rsp_id
);

  cand_t            cands [NUM_LR];
  logic [LR_W-1:0]  lrs   [NUM_LR];
  logic             root_qual;
  logic [IDX_W-1:0] root_idx;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_ent
    assign lrs[i] = lr_flat[i*LR_W +: LR_W];
    vpsel_entry_qual u_qual (
      .lr      (lrs[i]),
      .en_grp0 (en_grp0),
      .en_grp1 (en_grp1),
      .cand    (cands[i])
    );
  end

  vpsel_prio_tree #(.NUM_LR(NUM_LR)) u_tree (
    .cands     (cands),
    .root_qual (root_qual),
    .root_idx  (root_idx)
  );

  always_comb begin
    win_none = !root_qual;
    win_idx  = root_qual ? root_idx : '0;
    win_lr   = lrs[win_idx];
  end

  vpsel_rsp_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_none  (win_none),
    .win_grp   (win_lr[GRP_BIT]),
    .win_vid   (win_lr[VID_LSB +: VID_W]),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_grp   (req_grp),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_id    (rsp_id)
  );

  // R1: only pending entries are reported
  p_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !win_none |-> win_lr[STATE_LSB +: 2] == 2'b01);

  // R2: both groups off leaves no winner
  p_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_grp0 && !en_grp1 |-> win_none && win_idx == '0);

  // R3: winner's group is enabled
  p_grp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_none |-> (win_lr[GRP_BIT] ? en_grp1 : en_grp0));

  // R4: idle priority never wins
  p_noidle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !win_none |-> win_lr[PRIO_LSB +: PRIO_W] != PRIO_IDLE);

endmodule

// File: tb/tb_vpsel_top.sv
module tb_vpsel_top;

  localparam int N = 5;
  localparam int IW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*64-1:0] lr_flat = '0;
  logic            en_grp0 = 1'b0, en_grp1 = 1'b0;
  logic            win_none;
  logic [IW-1:0]   win_idx;
  logic [63:0]     win_lr;
  logic            req_valid = 1'b0, req_ready, req_grp = 1'b0;
  logic            rsp_valid, rsp_ready = 1'b1;
  logic [31:0]     rsp_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vpsel_top #(.NUM_LR(N)) dut (
    .clk(clk), .rst_n(rst_n), .lr_flat(lr_flat), .en_grp0(en_grp0), .en_grp1(en_grp1),
    .win_none(win_none), .win_idx(win_idx), .win_lr(win_lr),
    .req_valid(req_valid), .req_ready(req_ready), .req_grp(req_grp),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [1:0] st, input bit g,
                                     input logic [7:0] pr, input logic [31:0] vid);
    logic [63:0] e = '0;
    e[63:62] = st; e[60] = g; e[55:48] = pr; e[31:0] = vid;
    e[44:32] = 13'h0A5;
    return e;
  endfunction

  function automatic void ref_pick(input logic [N*64-1:0] lrs, input bit e0, input bit e1,
                                   output bit none, output int idx);
    int best = 255;
    none = 1; idx = 0;
    if (!e0 && !e1) return;
    for (int i = 0; i < N; i++) begin
      logic [63:0] e = lrs[i*64 +: 64];
      if (e[63:62] != 2'b01) continue;
      if (e[60] ? !e1 : !e0) continue;
      if (int'(e[55:48]) < best) begin
        best = int'(e[55:48]); idx = i; none = 0;
      end
    end
  endfunction

  function automatic logic [31:0] ref_rsp(input logic [N*64-1:0] lrs, input bit e0,
                                          input bit e1, input bit g);
    bit none; int idx;
    ref_pick(lrs, e0, e1, none, idx);
    if (none) return 32'd1023;
    if (lrs[idx*64+60] != g) return 32'd1023;
    return lrs[idx*64 +: 32];
  endfunction

  // One query: drive at negedge, check selection, check response one edge later
  task automatic run_one(input logic [N*64-1:0] lrs, input bit e0, input bit e1,
                         input bit g, input string req);
    bit none; int idx; logic [31:0] exp_id;
    @(negedge clk);
    lr_flat = lrs; en_grp0 = e0; en_grp1 = e1; req_grp = g;
    req_valid = 1'b1; rsp_ready = 1'b1;
    #1;
    ref_pick(lrs, e0, e1, none, idx);
    exp_id = ref_rsp(lrs, e0, e1, g);
    chk(win_none == none, req, "win_none", 64'(win_none), 64'(none));
    chk(int'(win_idx) == idx, req, "win_idx", 64'(win_idx), 64'(idx));
    chk(win_lr == lrs[idx*64 +: 64], "R5", "win_lr", win_lr, lrs[idx*64 +: 64]);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R7", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_id == exp_id, "R6", "rsp_id", 64'(rsp_id), 64'(exp_id));
  endtask

  function automatic logic [7:0] rnd_prio();
    case ($urandom_range(0, 4))
      0, 1: return 8'h40;
      2: return 8'h80;
      3: return 8'hFF;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*64-1:0] l;
    void'($urandom(32'd20250));
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk(req_ready == 1'b1, "R8", "req_ready in reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", 64'(rsp_valid), 64'd0);

    // R1: non-pending states skipped; only entry 3 pending
    l = '0;
    l[0*64 +: 64] = mk(2'b10, 0, 8'h01, 32'h11);
    l[1*64 +: 64] = mk(2'b11, 0, 8'h02, 32'h22);
    l[2*64 +: 64] = mk(2'b00, 0, 8'h03, 32'h33);
    l[3*64 +: 64] = mk(2'b01, 0, 8'h70, 32'h44);
    l[4*64 +: 64] = mk(2'b10, 1, 8'h00, 32'h55);
    run_one(l, 1, 1, 0, "R1");

    // R2: both enables low
    run_one(l, 0, 0, 0, "R2");

    // R3: group filtering; group-1 entry best but group 1 disabled
    l = '0;
    l[0*64 +: 64] = mk(2'b01, 1, 8'h10, 32'hA0);
    l[2*64 +: 64] = mk(2'b01, 0, 8'h30, 32'hA2);
    run_one(l, 1, 0, 0, "R3");
    run_one(l, 0, 1, 1, "R3");

    // R4: all idle priority
    l = '0;
    for (int i = 0; i < N; i++) l[i*64 +: 64] = mk(2'b01, i[0], 8'hFF, 32'(i));
    run_one(l, 1, 1, 1, "R4");

    // R5: three-way tie, lowest index wins
    l = '0;
    l[1*64 +: 64] = mk(2'b01, 0, 8'h20, 32'hB1);
    l[3*64 +: 64] = mk(2'b01, 1, 8'h20, 32'hB3);
    l[4*64 +: 64] = mk(2'b01, 0, 8'h20, 32'hB4);
    run_one(l, 1, 1, 0, "R5");

    // R6: winner of group 1 requested as group 0 -> spurious, no fallback
    l = '0;
    l[0*64 +: 64] = mk(2'b01, 1, 8'h05, 32'hC0);
    l[1*64 +: 64] = mk(2'b01, 0, 8'h06, 32'hC1);
    run_one(l, 1, 1, 0, "R6");

    // R7: stall the response slot
    @(negedge clk);
    lr_flat = l; en_grp0 = 1; en_grp1 = 1; req_grp = 1; req_valid = 1; rsp_ready = 0;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R7", "stalled rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_id == 32'hC0, "R7", "stalled rsp_id", 64'(rsp_id), 64'hC0);
    chk(req_ready == 1'b0, "R7", "req_ready while stalled", 64'(req_ready), 64'd0);
    req_grp = 0;
    @(negedge clk);
    chk(rsp_id == 32'hC0, "R7", "rsp_id held", 64'(rsp_id), 64'hC0);
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7", "slot drained", 64'(rsp_valid), 64'd0);

    // R5 R6: random trials
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < N; i++)
        l[i*64 +: 64] = mk(2'($urandom), 1'($urandom), rnd_prio(), $urandom);
      run_one(l, 1'($urandom), 1'($urandom), 1'($urandom), "R5");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule